// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad of 16 KB. The storage is split into sixteen interleaved banks, each one 32-bit word wide. A single issue carries one group request of up to sixteen lanes. Each lane has a valid flag, a byte address, a write flag, 32 bits of write data and four byte enables. Consecutive words land in consecutive banks. A group whose lanes touch distinct banks, or the same word of a bank, completes in one round.

When two or more lanes need different words of the same bank, the block splits the request into several bank-access rounds. In each round, every bank serves the word of its lowest-numbered lane that is still pending. Every lane waiting on that word completes in that round. Conflicts are judged only among the lanes of one request. After the last round, the block presents the full word for every reading lane, pulses done for one cycle and reports how many rounds the request took.

Top module: `spad_banked`

## Requirements
- R1: Byte address bits [1:0] select the byte in a word, bits [5:2] select the bank, and bits [13:6] select the row inside that bank. Word index w = addr[13:2] therefore lives in bank w mod 16.
- R2: A request whose valid lanes all fall in distinct banks completes in exactly one round.
- R3: The round count equals the largest number of distinct words that the valid lanes request from any single bank. The count is never below 1 and never above the lane count.
- R4: Lanes that address the same word, including different bytes or halfwords of it, are served together in one round and all receive that word.
- R5: Round counts depend only on the lanes of the current request. Two requests issued back to back never slow each other, even when they use the same bank.
- R6: A write updates only the bytes whose enable bit is set. Byte enable bit k covers bits [8k+7:8k] of the word.
- R7: When several lanes of one request write the same byte of the same word, the highest-numbered lane's data is stored.
- R8: A read served in the same round as a write to the same word returns the word as it was before that round's write.
- R9: Lanes with the valid bit low neither read, write nor cost a round. A request with no valid lane completes in one round.
- R10: A request is taken only in a cycle where ready_o is high. ready_o is low while rounds are in progress. done_o is high for exactly one cycle, in the cycle after the last round, together with rounds_o and the read data of all reading lanes.
- R11: After reset, ready_o is high and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Group request present |
| ready_o | output | 1 | Block idle, able to take a request |
| lane_valid_i | input | 16 | Per-lane valid flags |
| lane_addr_i | input | 224 | Per-lane byte addresses, 14 bits each, lane i at [14i+13:14i] |
| lane_we_i | input | 16 | Per-lane write flags (1 = write) |
| lane_wdata_i | input | 512 | Per-lane write data, 32 bits each |
| lane_be_i | input | 64 | Per-lane byte enables, 4 bits each |
| done_o | output | 1 | One-cycle completion pulse |
| rounds_o | output | 5 | Number of rounds used by the finished request |
| lane_rdata_o | output | 512 | Per-lane read word, 32 bits each |

## Verification
The assertions check the handshake on every cycle. They confirm that a taken request drops ready, that done is a single-cycle pulse seen only while idle, and that rounds_o matches the number of busy cycles the checker counted itself. They also confirm that rounds_o stays between 1 and the lane count and that an empty request finishes after one round. The bench scenarios are the only evidence for the rest. These cover the bank and row mapping, the exact round count for a given address mix, the broadcast of a shared word, byte-enable merging, the highest-lane priority on write clashes, the value returned by a read that meets a write in the same round, and the fact that invalid lanes and requests held during a busy period leave memory untouched.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spad_state_e;
endpackage

// File: rtl/spad_addr_split.sv
module spad_addr_split #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BYTE_W = 2,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned ROW_W  = 8
) (
  input  logic [LANES*ADDR_W-1:0] addr_i,
  output logic [LANES*BANK_W-1:0] bank_o,
  output logic [LANES*ROW_W-1:0]  row_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr_i[i*ADDR_W +: ADDR_W];
    assign bank_o[i*BANK_W +: BANK_W] = a[BYTE_W +: BANK_W];
    assign row_o[i*ROW_W +: ROW_W]    = a[BYTE_W+BANK_W +: ROW_W];
  end
endmodule

// File: rtl/spad_round_pick.sv
module spad_round_pick #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned BANKS  = 16,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic [LANES-1:0]        pend_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [LANES*BANK_W-1:0] bank_i,
  input  logic [LANES*ROW_W-1:0]  row_i,
  input  logic [LANES*WORD_W-1:0] wdata_i,
  input  logic [LANES*WORD_W/8-1:0] be_i,
  output logic [LANES-1:0]        serve_o,
  output logic [BANKS-1:0]        bank_wen_o,
  output logic [BANKS*ROW_W-1:0]  bank_row_o,
  output logic [BANKS*WORD_W-1:0] bank_wdata_o,
  output logic [BANKS*WORD_W/8-1:0] bank_be_o
);
  localparam int unsigned BE_W = WORD_W / 8;

  logic [BANKS-1:0] lead_ok;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              found;
    logic [ROW_W-1:0]  lrow;
    logic              wen;
    logic [WORD_W-1:0] wd;
    logic [BE_W-1:0]   be;

    // leader = lowest pending lane mapped to this bank
    always_comb begin
      found = 1'b0;
      lrow  = '0;
      for (int i = 0; i < LANES; i++) begin
        if (!found && pend_i[i] && bank_i[i*BANK_W +: BANK_W] == BANK_W'(b)) begin
          found = 1'b1;
          lrow  = row_i[i*ROW_W +: ROW_W];
        end
      end
    end

    // merge writes of all lanes on the leader word; later lanes override
    always_comb begin
      wen = 1'b0;
      wd  = '0;
      be  = '0;
      for (int i = 0; i < LANES; i++) begin
        if (found && pend_i[i] && we_i[i] &&
            bank_i[i*BANK_W +: BANK_W] == BANK_W'(b) &&
            row_i[i*ROW_W +: ROW_W] == lrow) begin
          wen = 1'b1;
          for (int k = 0; k < BE_W; k++) begin
            if (be_i[i*BE_W + k]) begin
              be[k]        = 1'b1;
              wd[k*8 +: 8] = wdata_i[i*WORD_W + k*8 +: 8];
            end
          end
        end
      end
    end

    assign lead_ok[b]                        = found;
    assign bank_row_o[b*ROW_W +: ROW_W]      = lrow;
    assign bank_wen_o[b]                     = wen;
    assign bank_wdata_o[b*WORD_W +: WORD_W]  = wd;
    assign bank_be_o[b*BE_W +: BE_W]         = be;
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [BANK_W-1:0] bk;
      bk = bank_i[i*BANK_W +: BANK_W];
      serve_o[i] = pend_i[i] && lead_ok[bk] &&
                   (row_i[i*ROW_W +: ROW_W] == bank_row_o[int'(bk)*ROW_W +: ROW_W]);
    end
  end
endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                wen_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [WORD_W/8-1:0] be_i,
  output logic [WORD_W-1:0]   rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  // read returns the pre-write word of this cycle
  assign rdata_o = mem[row_i];

  always_ff @(posedge clk_i) begin
    if (wen_i) begin
      for (int k = 0; k < WORD_W/8; k++) begin
        if (be_i[k]) mem[row_i][k*8 +: 8] <= wdata_i[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/spad_banked.sv
module spad_banked
  import spad_pkg::*;
#(
  parameter int unsigned LANES     = 16,
  parameter int unsigned BANKS     = 16,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned CAP_BYTES = 16384
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_valid_i,
  output logic                                ready_o,
  input  logic [LANES-1:0]                    lane_valid_i,
  input  logic [LANES*$clog2(CAP_BYTES)-1:0]  lane_addr_i,
  input  logic [LANES-1:0]                    lane_we_i,
  input  logic [LANES*WORD_W-1:0]             lane_wdata_i,
  input  logic [LANES*WORD_W/8-1:0]           lane_be_i,
  output logic                                done_o,
  output logic [$clog2(LANES+1)-1:0]          rounds_o,
  output logic [LANES*WORD_W-1:0]             lane_rdata_o
);
  localparam int unsigned BE_W   = WORD_W / 8;
  localparam int unsigned BYTE_W = $clog2(BE_W);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ADDR_W = $clog2(CAP_BYTES);
  localparam int unsigned ROW_W  = ADDR_W - BANK_W - BYTE_W;
  localparam int unsigned DEPTH  = CAP_BYTES / (BANKS * BE_W);
  localparam int unsigned RND_W  = $clog2(LANES + 1);

  spad_state_e               state_q;
  logic [LANES-1:0]          pend_q, we_q, serve, pend_next;
  logic [LANES*ADDR_W-1:0]   addr_q;
  logic [LANES*WORD_W-1:0]   wdata_q, rdata_q, lane_rd;
  logic [LANES*BE_W-1:0]     be_q;
  logic                      done_q;
  logic [RND_W-1:0]          rounds_q, rcnt_q;

  logic [LANES*BANK_W-1:0]   lane_bank;
  logic [LANES*ROW_W-1:0]    lane_row;
  logic [BANKS-1:0]          bank_wen;
  logic [BANKS*ROW_W-1:0]    bank_row;
  logic [BANKS*WORD_W-1:0]   bank_wdata, bank_rdata;
  logic [BANKS*BE_W-1:0]     bank_be;

  spad_addr_split #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_split (
    .addr_i (addr_q),
    .bank_o (lane_bank),
    .row_o  (lane_row)
  );

  spad_round_pick #(
    .LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .WORD_W(WORD_W)
  ) u_pick (
    .pend_i       (pend_q),
    .we_i         (we_q),
    .bank_i       (lane_bank),
    .row_i        (lane_row),
    .wdata_i      (wdata_q),
    .be_i         (be_q),
    .serve_o      (serve),
    .bank_wen_o   (bank_wen),
    .bank_row_o   (bank_row),
    .bank_wdata_o (bank_wdata),
    .bank_be_o    (bank_be)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    spad_bank #(.DEPTH(DEPTH), .ROW_W(ROW_W), .WORD_W(WORD_W)) u_bank (
      .clk_i   (clk_i),
      .wen_i   (bank_wen[b]),
      .row_i   (bank_row[b*ROW_W +: ROW_W]),
      .wdata_i (bank_wdata[b*WORD_W +: WORD_W]),
      .be_i    (bank_be[b*BE_W +: BE_W]),
      .rdata_o (bank_rdata[b*WORD_W +: WORD_W])
    );
  end

  // route each lane to its bank's read port
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_rd[i*WORD_W +: WORD_W] =
        bank_rdata[int'(lane_bank[i*BANK_W +: BANK_W])*WORD_W +: WORD_W];
    end
  end

  assign pend_next = pend_q & ~serve;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      we_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      rounds_q <= '0;
      rcnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            pend_q  <= lane_valid_i;
            we_q    <= lane_we_i;
            addr_q  <= lane_addr_i;
            wdata_q <= lane_wdata_i;
            be_q    <= lane_be_i;
            rcnt_q  <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          pend_q <= pend_next;
          rcnt_q <= rcnt_q + 1'b1;
          for (int i = 0; i < LANES; i++) begin
            if (serve[i] && !we_q[i]) rdata_q[i*WORD_W +: WORD_W] <= lane_rd[i*WORD_W +: WORD_W];
          end
          if (pend_next == '0) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            rounds_q <= rcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign done_o       = done_q;
  assign rounds_o     = rounds_q;
  assign lane_rdata_o = rdata_q;
endmodule

// File: rtl/spad_checker.sv
module spad_checker #(
  parameter int unsigned LANES = 16,
  parameter int unsigned RND_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             ready_o,
  input logic [LANES-1:0] lane_valid_i,
  input logic             done_o,
  input logic [RND_W-1:0] rounds_o
);
  // busy cycles since the last taken request
  logic [RND_W:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else if (req_valid_i && ready_o) busy_cnt_q <= '0;
    else if (!ready_o) busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  a_r10_take_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> !ready_o);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  a_r10_rounds_match_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (RND_W+1)'(rounds_o) == busy_cnt_q);

  a_r3_round_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rounds_o >= 1 && rounds_o <= RND_W'(LANES)));

  a_r3_busy_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> busy_cnt_q < (RND_W+1)'(LANES));

  a_r9_empty_one_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o && lane_valid_i == '0) |=> ##1 (done_o && rounds_o == RND_W'(1)));
endmodule

bind spad_banked spad_checker #(.LANES(LANES), .RND_W($clog2(LANES+1))) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .ready_o      (ready_o),
  .lane_valid_i (lane_valid_i),
  .done_o       (done_o),
  .rounds_o     (rounds_o)
);

// File: tb/spad_banked_bench.sv
module spad_banked_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            req_valid = 1'b0;
  logic            ready;
  logic [L-1:0]    lane_valid = '0;
  logic [L*14-1:0] lane_addr = '0;
  logic [L-1:0]    lane_we = '0;
  logic [L*32-1:0] lane_wdata = '0;
  logic [L*4-1:0]  lane_be = '0;
  logic            done;
  logic [4:0]      rounds;
  logic [L*32-1:0] lane_rdata;

  spad_banked u_spad_banked (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .ready_o(ready),
    .lane_valid_i(lane_valid), .lane_addr_i(lane_addr), .lane_we_i(lane_we),
    .lane_wdata_i(lane_wdata), .lane_be_i(lane_be), .done_o(done),
    .rounds_o(rounds), .lane_rdata_o(lane_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [L-1:0] t_valid, t_we;
  logic [13:0]  t_addr [L];
  logic [31:0]  t_wd [L];
  logic [3:0]   t_be [L];
  logic [31:0]  ref_mem [4096];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_req();
    t_valid = '0;
    t_we = '0;
    for (int i = 0; i < L; i++) begin
      t_addr[i] = '0; t_wd[i] = '0; t_be[i] = '0;
    end
  endtask

  task automatic drive();
    lane_valid = t_valid;
    lane_we = t_we;
    for (int i = 0; i < L; i++) begin
      lane_addr[i*14 +: 14] = t_addr[i];
      lane_wdata[i*32 +: 32] = t_wd[i];
      lane_be[i*4 +: 4] = t_be[i];
    end
  endtask

  // R1/R3: per bank (addr[5:2]) count distinct words (addr[13:2]); max, at least 1
  function automatic int exp_rounds();
    int best;
    best = 1;
    for (int b = 0; b < 16; b++) begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < L; i++) begin
        if (t_valid[i] && t_addr[i][5:2] == 4'(b)) begin
          bit seen;
          seen = 1'b0;
          for (int j = 0; j < i; j++)
            if (t_valid[j] && t_addr[j][13:2] == t_addr[i][13:2]) seen = 1'b1;
          if (!seen) cnt++;
        end
      end
      if (cnt > best) best = cnt;
    end
    return best;
  endfunction

  task automatic run_req(input string tag, input int hold);
    logic [31:0] exp_rd [L];
    int er;
    int g;
    for (int i = 0; i < L; i++) exp_rd[i] = ref_mem[t_addr[i][13:2]];
    er = exp_rounds();
    @(negedge clk);
    check(ready === 1'b1, "R10", {tag, " ready before issue"}, 32'(ready), 32'd1);
    drive();
    req_valid = 1'b1;
    @(negedge clk);
    if (hold > 0) begin
      // stray request while busy: must be ignored (R10)
      lane_valid = '1; lane_we = '1;
      for (int i = 0; i < L; i++) begin
        lane_addr[i*14 +: 14] = 14'(200 * 4);
        lane_wdata[i*32 +: 32] = 32'hDEADBEEF;
        lane_be[i*4 +: 4] = 4'hF;
      end
      repeat (hold) @(negedge clk);
    end
    req_valid = 1'b0;
    g = 0;
    while (!done && g < 64) begin
      @(negedge clk);
      g++;
    end
    check(done === 1'b1, "R10", {tag, " done seen"}, 32'(done), 32'd1);
    check(rounds == 5'(er), tag, "rounds", 32'(rounds), 32'(er));
    for (int i = 0; i < L; i++) begin
      if (t_valid[i] && !t_we[i])
        check(lane_rdata[i*32 +: 32] === exp_rd[i], tag, $sformatf("lane %0d rdata", i),
              lane_rdata[i*32 +: 32], exp_rd[i]);
    end
    @(negedge clk);
    check(done === 1'b0, "R10", {tag, " done one cycle"}, 32'(done), 32'd0);
    // reference update, lanes in ascending order so the highest wins (R6, R7)
    for (int i = 0; i < L; i++) begin
      if (t_valid[i] && t_we[i])
        for (int k = 0; k < 4; k++)
          if (t_be[i][k]) ref_mem[t_addr[i][13:2]][k*8 +: 8] = t_wd[i][k*8 +: 8];
    end
  endtask

  task automatic set_lane(input int i, input int word, input bit we,
                          input logic [31:0] d, input logic [3:0] be);
    t_valid[i] = 1'b1;
    t_we[i] = we;
    t_addr[i] = 14'(word * 4);
    t_wd[i] = d;
    t_be[i] = be;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    for (int w = 0; w < 4096; w++) ref_mem[w] = 'x;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ready === 1'b1, "R11", "ready in reset", 32'(ready), 32'd1);
    check(done === 1'b0, "R11", "done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1 && done === 1'b0, "R11", "after reset", {30'd0, ready, done}, 32'h2);

    // fill words 0..255, one bank per lane (R2)
    for (int r = 0; r < 16; r++) begin
      clear_req();
      for (int i = 0; i < L; i++) set_lane(i, r*16 + i, 1'b1, $urandom, 4'hF);
      run_req("R2", 0);
    end

    // R2 all banks distinct read
    clear_req();
    for (int i = 0; i < L; i++) set_lane(i, 32 + i, 1'b0, '0, '0);
    run_req("R2", 0);

    // R3 all lanes bank 0, distinct rows -> 16 rounds; stray request held (R10)
    clear_req();
    for (int i = 0; i < L; i++) set_lane(i, i*16, 1'b0, '0, '0);
    run_req("R3", 3);
    clear_req();
    set_lane(0, 200, 1'b0, '0, '0);
    run_req("R10", 0);

    // R3 word i and i+16 in one request -> 2 rounds
    clear_req();
    set_lane(0, 3, 1'b0, '0, '0);
    set_lane(1, 19, 1'b0, '0, '0);
    run_req("R3", 0);

    // R5 same bank, separate requests -> 1 round each
    clear_req(); set_lane(0, 3, 1'b0, '0, '0); run_req("R5", 0);
    clear_req(); set_lane(0, 19, 1'b0, '0, '0); run_req("R5", 0);

    // R4 broadcast: bytes and halfwords of one word
    clear_req();
    for (int i = 0; i < L; i++) set_lane(i, 5, 1'b0, '0, '0);
    t_addr[1] = 14'(5*4 + 1); t_addr[2] = 14'(5*4 + 2); t_addr[3] = 14'(5*4 + 3);
    run_req("R4", 0);

    // R1 top of capacity: word 4095 (bank 15, row 255) and word 4079 conflict
    clear_req();
    set_lane(0, 4095, 1'b1, 32'hA5A5_0F0F, 4'hF);
    set_lane(1, 4079, 1'b1, 32'h1234_5678, 4'hF);
    run_req("R1", 0);
    clear_req();
    set_lane(0, 4095, 1'b0, '0, '0);
    set_lane(1, 4079, 1'b0, '0, '0);
    set_lane(2, 15, 1'b0, '0, '0);
    run_req("R1", 0);

    // R6 partial byte enable, then read
    clear_req(); set_lane(0, 7, 1'b1, 32'hCAFE_BABE, 4'b0101); run_req("R6", 0);
    clear_req(); set_lane(0, 7, 1'b0, '0, '0); run_req("R6", 0);

    // R7 four lanes write the same byte
    clear_req();
    for (int i = 0; i < 4; i++) set_lane(i, 9, 1'b1, 32'(i + 8'h10) << 8, 4'b0010);
    run_req("R7", 0);
    clear_req(); set_lane(0, 9, 1'b0, '0, '0); run_req("R7", 0);

    // R8 read and write of one word in the same round
    clear_req();
    set_lane(0, 11, 1'b1, 32'h0BAD_F00D, 4'hF);
    set_lane(1, 11, 1'b0, '0, '0);
    run_req("R8", 0);
    clear_req(); set_lane(0, 11, 1'b0, '0, '0); run_req("R8", 0);

    // R9 invalid write lane leaves memory alone; empty request
    clear_req();
    set_lane(5, 12, 1'b1, 32'hFFFF_FFFF, 4'hF);
    t_valid[5] = 1'b0;
    set_lane(6, 28, 1'b0, '0, '0);
    run_req("R9", 0);
    clear_req(); set_lane(0, 12, 1'b0, '0, '0); run_req("R9", 0);
    clear_req(); run_req("R9", 0);

    // random mix: all-read or all-write requests over varying pools
    for (int n = 0; n < 300; n++) begin
      int pool;
      bit wr;
      pool = ($urandom % 3 == 0) ? 16 : (($urandom % 2) ? 64 : 256);
      wr = ($urandom % 3 == 0);
      clear_req();
      for (int i = 0; i < L; i++) begin
        if ($urandom % 8 != 0) begin
          set_lane(i, int'($urandom % pool), wr, $urandom, 4'($urandom));
          t_addr[i][1:0] = 2'($urandom);
        end
      end
      run_req(wr ? "R6" : "R3", 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule